// File: doc/BRIEF.md
# Two-Clock Cycle Ratio Meter

This block checks the frequency of a clock under test against a reference clock. Each clock drives its own counter. Each counter has its own hold-in-clear control, its own run control and its own programmed terminal count. Software programs both terminal counts over a small 32-bit bus slave. It then releases and starts both counters with one control write and reads back the two counts once they settle. The ratio of the two counts gives the frequency ratio of the two clocks.

The reference counter stops on its own terminal count. In the default build, that event also freezes the test counter, through a synchronised stop level in the test domain. The test count therefore covers the reference window plus a small crossing overhead. The test counter also stops on its own terminal count if it gets there first. Each counter that reaches its terminal count raises a sticky flag in the bus domain. The flag is visible in the control word and on an interrupt output. Control levels go into each counting domain through multi-flop synchronisers. Counts come back through a toggle handshake, so a 32-bit value is never read half-updated.

Top module: `ratio_meter`

## Requirements
- R1: After reset the control word reads 0x11 (both counters held clear), both maximum registers read 0xFFFFFFFF, both counts and the status word read 0, and both interrupt outputs are low.
- R2: The word offsets are: control 0x00, status 0x04, reference maximum 0x08, reference count 0x0C, test maximum 0x10, test count 0x14. The maximum registers read back the value written. Control bits 0/1 (reference clear/run) and 4/5 (test clear/run) read back as last written.
- R3: Every bus access is acknowledged for exactly one cycle, the cycle after it is presented. Reads of offsets 0x18 and 0x1C return 0.
- R4: Once released and started, the reference counter advances once per reference cycle and stops at a count equal to its maximum.
- R5: The test counter never passes its own maximum. When it reaches its maximum before the reference window closes, its count reads exactly that maximum.
- R6: With the test maximum out of reach, the test count covers the reference window: it lies between floor(Nref·Tref/Ttst) and that value plus 26 test cycles of crossing overhead.
- R7: Control bit 2 (reference) and bit 6 (test) are sticky terminal flags, mirrored on irq_ref and irq_tst. They set when the matching counter reaches its maximum while running. Bus writes to these bits have no effect.
- R8: While a clear bit is set, the matching counter reads 0 and its flag is cleared. A clear outranks a flag set in the same cycle.
- R9: Status bit 0 and bit 1 show the live terminal state of the reference and test counters, and read 0 while cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus and register clock |
| arst_n | input | 1 | Asynchronous active-low reset for all domains |
| ref_clk | input | 1 | Reference clock |
| tst_clk | input | 1 | Clock under test |
| wb_cyc | input | 1 | Bus cycle active |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Write enable |
| wb_adr | input | ADR_W | Byte address; bits above 1 select the word |
| wb_dat_w | input | DAT_W | Write data |
| wb_dat_r | output | DAT_W | Read data, valid with wb_ack |
| wb_ack | output | 1 | One-cycle acknowledge |
| irq_ref | output | 1 | Sticky reference terminal flag |
| irq_tst | output | 1 | Sticky test terminal flag |

## Verification
In the same short stretch, two events can coincide: the freeze that arrives from the closing reference window, and the test counter's own stop on its maximum. The bench provokes this by sweeping the test maximum across the expected frozen count for a fixed reference window. Whichever event wins, the test count must never pass the test maximum, and the test flag must be set exactly when the count equals the maximum. A second collision, a clear arriving in the same cycle as a flag set, is judged by requiring that a set clear bit always leaves the flag low on the next cycle.

// File: rtl/ratio_meter_pkg.sv
package ratio_meter_pkg;

   typedef enum logic [2:0] {
      IDX_CTRL = 3'd0,
      IDX_STAT = 3'd1,
      IDX_RMAX = 3'd2,
      IDX_RCNT = 3'd3,
      IDX_TMAX = 3'd4,
      IDX_TCNT = 3'd5
   } reg_idx_e;

   localparam int B_RCLR = 0;
   localparam int B_RRUN = 1;
   localparam int B_RFLG = 2;
   localparam int B_TCLR = 4;
   localparam int B_TRUN = 5;
   localparam int B_TFLG = 6;

   localparam logic [7:0] CTRL_RST = 8'h11;

endpackage

// File: rtl/ratio_sync.sv
module ratio_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ratio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/ratio_xfer.sv
module ratio_xfer #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         src_clk,
   input  logic         dst_clk,
   input  logic         arst_n,
   input  logic [W-1:0] src_d,
   output logic [W-1:0] dst_q
);

   logic         req_t, req_s;
   logic         ack_t, ack_s;
   logic [W-1:0] snap;

   ratio_sync #(.W(1), .STAGES(STAGES)) u_req (
      .clk(src_clk), .arst_n(arst_n), .d(req_t), .q(req_s));

   ratio_sync #(.W(1), .STAGES(STAGES)) u_ack (
      .clk(dst_clk), .arst_n(arst_n), .d(ack_t), .q(ack_s));

   // source side: a new request freezes a fresh snapshot, then answers
   always_ff @(posedge src_clk or negedge arst_n) begin
      if (!arst_n) begin
         snap  <= '0;
         ack_t <= 1'b0;
      end else if (req_s != ack_t) begin
         snap  <= src_d;
         ack_t <= req_s;
      end
   end

   // destination side: an answered request means snap is stable
   always_ff @(posedge dst_clk or negedge arst_n) begin
      if (!arst_n) begin
         dst_q <= '0;
         req_t <= 1'b0;
      end else if (ack_s == req_t) begin
         dst_q <= snap;
         req_t <= ~req_t;
      end
   end

endmodule

// File: rtl/ratio_lane.sv
module ratio_lane #(
   parameter int CNT_W  = 32,
   parameter int STAGES = 2
) (
   input  logic             cnt_clk,
   input  logic             arst_n,
   input  logic             clr_a,
   input  logic             run_a,
   input  logic             stop_a,
   input  logic [CNT_W-1:0] lim_a,
   output logic [CNT_W-1:0] cnt_q,
   output logic             done_q
);

   logic [2:0] ctl_s;
   logic       clr_s, run_s, stop_s;
   logic       at_lim;

   ratio_sync #(.W(3), .STAGES(STAGES)) u_ctl (
      .clk(cnt_clk), .arst_n(arst_n),
      .d({clr_a, run_a, stop_a}), .q(ctl_s));

   assign {clr_s, run_s, stop_s} = ctl_s;
   assign at_lim = (cnt_q == lim_a);

   always_ff @(posedge cnt_clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_q <= '0;
      end else if (clr_s) begin
         cnt_q <= '0;
      end else if (run_s && !stop_s && !at_lim) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge cnt_clk or negedge arst_n) begin
      if (!arst_n) done_q <= 1'b0;
      else         done_q <= run_s & ~clr_s & at_lim;
   end

endmodule

// File: rtl/ratio_regs.sv
module ratio_regs
   import ratio_meter_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int DAT_W = 32,
   parameter int ADR_W = 5
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             wb_cyc,
   input  logic             wb_stb,
   input  logic             wb_we,
   input  logic [ADR_W-1:0] wb_adr,
   input  logic [DAT_W-1:0] wb_dat_w,
   output logic [DAT_W-1:0] wb_dat_r,
   output logic             wb_ack,
   input  logic [CNT_W-1:0] ref_cnt_b,
   input  logic [CNT_W-1:0] tst_cnt_b,
   input  logic [1:0]       done_b,
   output logic             ref_clr,
   output logic             ref_run,
   output logic             tst_clr,
   output logic             tst_run,
   output logic [CNT_W-1:0] ref_lim,
   output logic [CNT_W-1:0] tst_lim,
   output logic             flag_ref,
   output logic             flag_tst
);

   logic       acc, wr, rd;
   logic [2:0] idx;
   logic       unused_lsb;
   logic [DAT_W-1:0] rd_word;

   assign acc        = wb_cyc & wb_stb & ~wb_ack;
   assign wr         = acc & wb_we;
   assign rd         = acc & ~wb_we;
   assign idx        = 3'(wb_adr[ADR_W-1:2]);
   assign unused_lsb = ^wb_adr[1:0];

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         ref_clr <= CTRL_RST[B_RCLR];
         ref_run <= CTRL_RST[B_RRUN];
         tst_clr <= CTRL_RST[B_TCLR];
         tst_run <= CTRL_RST[B_TRUN];
         ref_lim <= '1;
         tst_lim <= '1;
      end else if (wr) begin
         case (reg_idx_e'(idx))
            IDX_CTRL: begin
               ref_clr <= wb_dat_w[B_RCLR];
               ref_run <= wb_dat_w[B_RRUN];
               tst_clr <= wb_dat_w[B_TCLR];
               tst_run <= wb_dat_w[B_TRUN];
            end
            IDX_RMAX: ref_lim <= wb_dat_w[CNT_W-1:0];
            IDX_TMAX: tst_lim <= wb_dat_w[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   // sticky flags: a held clear beats a set in the same cycle
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         flag_ref <= 1'b0;
         flag_tst <= 1'b0;
      end else begin
         flag_ref <= ref_clr ? 1'b0 : (flag_ref | done_b[0]);
         flag_tst <= tst_clr ? 1'b0 : (flag_tst | done_b[1]);
      end
   end

   always_comb begin
      rd_word = '0;
      case (reg_idx_e'(idx))
         IDX_CTRL: begin
            rd_word[B_RCLR] = ref_clr;
            rd_word[B_RRUN] = ref_run;
            rd_word[B_RFLG] = flag_ref;
            rd_word[B_TCLR] = tst_clr;
            rd_word[B_TRUN] = tst_run;
            rd_word[B_TFLG] = flag_tst;
         end
         IDX_STAT: rd_word[1:0]       = done_b;
         IDX_RMAX: rd_word[CNT_W-1:0] = ref_lim;
         IDX_RCNT: rd_word[CNT_W-1:0] = ref_cnt_b;
         IDX_TMAX: rd_word[CNT_W-1:0] = tst_lim;
         IDX_TCNT: rd_word[CNT_W-1:0] = tst_cnt_b;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         wb_ack   <= 1'b0;
         wb_dat_r <= '0;
      end else begin
         wb_ack   <= acc;
         wb_dat_r <= rd ? rd_word : '0;
      end
   end

endmodule

// File: rtl/ratio_meter.sv
module ratio_meter #(
   parameter int CNT_W         = 32,
   parameter int DAT_W         = 32,
   parameter int ADR_W         = 5,
   parameter int SYNC_STAGES   = 2,
   parameter int FREEZE_ON_REF = 1
) (
   input  logic             bus_clk,
   input  logic             arst_n,
   input  logic             ref_clk,
   input  logic             tst_clk,
   input  logic             wb_cyc,
   input  logic             wb_stb,
   input  logic             wb_we,
   input  logic [ADR_W-1:0] wb_adr,
   input  logic [DAT_W-1:0] wb_dat_w,
   output logic [DAT_W-1:0] wb_dat_r,
   output logic             wb_ack,
   output logic             irq_ref,
   output logic             irq_tst
);

   if (CNT_W < 2 || CNT_W > DAT_W) begin : g_bad_cnt
      $error("ratio_meter: CNT_W must lie in 2..DAT_W");
   end
   if (ADR_W < 5) begin : g_bad_adr
      $error("ratio_meter: ADR_W must be at least 5");
   end

   logic             ref_clr, ref_run, tst_clr, tst_run;
   logic [CNT_W-1:0] ref_lim, tst_lim;
   logic [CNT_W-1:0] ref_cnt, tst_cnt;
   logic [CNT_W-1:0] ref_cnt_b, tst_cnt_b;
   logic             ref_done, tst_done, tst_stop;
   logic [1:0]       done_b;

   if (FREEZE_ON_REF != 0) begin : g_freeze
      assign tst_stop = ref_done;
   end else begin : g_free_run
      assign tst_stop = 1'b0;
   end

   ratio_lane #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_ref_lane (
      .cnt_clk(ref_clk), .arst_n(arst_n),
      .clr_a(ref_clr), .run_a(ref_run), .stop_a(1'b0),
      .lim_a(ref_lim), .cnt_q(ref_cnt), .done_q(ref_done));

   ratio_lane #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_tst_lane (
      .cnt_clk(tst_clk), .arst_n(arst_n),
      .clr_a(tst_clr), .run_a(tst_run), .stop_a(tst_stop),
      .lim_a(tst_lim), .cnt_q(tst_cnt), .done_q(tst_done));

   ratio_xfer #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_ref_xfer (
      .src_clk(ref_clk), .dst_clk(bus_clk), .arst_n(arst_n),
      .src_d(ref_cnt), .dst_q(ref_cnt_b));

   ratio_xfer #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_tst_xfer (
      .src_clk(tst_clk), .dst_clk(bus_clk), .arst_n(arst_n),
      .src_d(tst_cnt), .dst_q(tst_cnt_b));

   ratio_sync #(.W(2), .STAGES(SYNC_STAGES)) u_done_sync (
      .clk(bus_clk), .arst_n(arst_n),
      .d({tst_done, ref_done}), .q(done_b));

   ratio_regs #(.CNT_W(CNT_W), .DAT_W(DAT_W), .ADR_W(ADR_W)) u_regs (
      .clk(bus_clk), .arst_n(arst_n),
      .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
      .wb_adr(wb_adr), .wb_dat_w(wb_dat_w),
      .wb_dat_r(wb_dat_r), .wb_ack(wb_ack),
      .ref_cnt_b(ref_cnt_b), .tst_cnt_b(tst_cnt_b), .done_b(done_b),
      .ref_clr(ref_clr), .ref_run(ref_run),
      .tst_clr(tst_clr), .tst_run(tst_run),
      .ref_lim(ref_lim), .tst_lim(tst_lim),
      .flag_ref(irq_ref), .flag_tst(irq_tst));

endmodule

// File: rtl/ratio_meter_chk.sv
module ratio_meter_chk #(
   parameter int CNT_W = 32,
   parameter int DAT_W = 32,
   parameter int ADR_W = 5
) (
   input logic             bus_clk,
   input logic             tst_clk,
   input logic             arst_n,
   input logic             wb_we,
   input logic [ADR_W-1:0] wb_adr,
   input logic [DAT_W-1:0] wb_dat_r,
   input logic             wb_ack,
   input logic             ref_clr,
   input logic             tst_clr,
   input logic             irq_ref,
   input logic             irq_tst,
   input logic             tst_done,
   input logic [CNT_W-1:0] tst_cnt
);

   AST_ACK_PULSE: assert property (@(posedge bus_clk) disable iff (!arst_n)
      wb_ack |=> !wb_ack); // R3

   AST_UNDEF_ZERO: assert property (@(posedge bus_clk) disable iff (!arst_n)
      (wb_ack && !$past(wb_we) && ($past(wb_adr[ADR_W-1:2]) > 5)) |-> (wb_dat_r == '0)); // R3

   AST_REF_FLAG_CLEAR: assert property (@(posedge bus_clk) disable iff (!arst_n)
      ref_clr |=> !irq_ref); // R8

   AST_TST_FLAG_CLEAR: assert property (@(posedge bus_clk) disable iff (!arst_n)
      tst_clr |=> !irq_tst); // R8

   AST_REF_FLAG_STICKY: assert property (@(posedge bus_clk) disable iff (!arst_n)
      (irq_ref && !ref_clr) |=> irq_ref); // R7

   AST_TST_FLAG_STICKY: assert property (@(posedge bus_clk) disable iff (!arst_n)
      (irq_tst && !tst_clr) |=> irq_tst); // R7

   AST_TST_HOLD_AT_MAX: assert property (@(posedge tst_clk) disable iff (!arst_n)
      tst_done |=> (!tst_done || $stable(tst_cnt))); // R5

endmodule

bind ratio_meter ratio_meter_chk #(.CNT_W(CNT_W), .DAT_W(DAT_W), .ADR_W(ADR_W)) u_chk (
   .bus_clk(bus_clk), .tst_clk(tst_clk), .arst_n(arst_n),
   .wb_we(wb_we), .wb_adr(wb_adr), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack),
   .ref_clr(ref_clr), .tst_clr(tst_clr),
   .irq_ref(irq_ref), .irq_tst(irq_tst),
   .tst_done(tst_done), .tst_cnt(tst_cnt));

// File: tb/ratio_meter_test.sv
module ratio_meter_test;

   localparam int TREF = 70;
   localparam int TTST = 16;

   logic        bus_clk = 1'b0;
   logic        ref_clk = 1'b0;
   logic        tst_clk = 1'b0;
   logic        arst_n  = 1'b0;
   logic        wb_cyc  = 1'b0;
   logic        wb_stb  = 1'b0;
   logic        wb_we   = 1'b0;
   logic [4:0]  wb_adr  = '0;
   logic [31:0] wb_dat_w = '0;
   logic [31:0] wb_dat_r;
   logic        wb_ack;
   logic        irq_ref, irq_tst;

   int n_vec  = 0;
   int n_fail = 0;

   always #10 bus_clk = ~bus_clk;
   always #(TREF/2) ref_clk = ~ref_clk;
   always #(TTST/2) tst_clk = ~tst_clk;

   ratio_meter uut (
      .bus_clk(bus_clk), .arst_n(arst_n), .ref_clk(ref_clk), .tst_clk(tst_clk),
      .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
      .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack),
      .irq_ref(irq_ref), .irq_tst(irq_tst));

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic chk_rng(input string req, input logic [31:0] got,
                          input logic [31:0] lo, input logic [31:0] hi);
      n_vec++;
      if (got < lo || got > hi) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d..%0d", req, got, lo, hi);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge bus_clk);
   endtask

   task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge bus_clk);
      wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b1; wb_adr = a; wb_dat_w = d;
      do @(negedge bus_clk); while (!wb_ack);
      wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge bus_clk);
      wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b0; wb_adr = a;
      do @(negedge bus_clk); while (!wb_ack);
      d = wb_dat_r;
      wb_cyc = 1'b0; wb_stb = 1'b0;
   endtask

   // clear both, program limits, start both, wait for reference terminal
   task automatic measure(input logic [31:0] rlim, input logic [31:0] tlim);
      logic [31:0] v;
      bus_wr(5'h00, 32'h11);
      idle(60);
      bus_wr(5'h08, rlim);
      bus_wr(5'h10, tlim);
      bus_wr(5'h00, 32'h22);
      for (int k = 0; k < 3000; k++) begin
         bus_rd(5'h00, v);
         if (v[2]) break;
      end
      idle(80);
   endtask

   initial begin
      repeat (150000) @(posedge bus_clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [31:0] nom;
      idle(3);
      arst_n = 1'b1;
      idle(80);

      // R1 reset state
      bus_rd(5'h00, v); chk("R1 ctrl", v, 32'h11);
      bus_rd(5'h08, v); chk("R1 ref max", v, 32'hFFFF_FFFF);
      bus_rd(5'h10, v); chk("R1 tst max", v, 32'hFFFF_FFFF);
      bus_rd(5'h0C, v); chk("R1 ref cnt", v, 0);
      bus_rd(5'h14, v); chk("R1 tst cnt", v, 0);
      bus_rd(5'h04, v); chk("R1 status", v, 0);
      chk("R1 irq", {30'd0, irq_tst, irq_ref}, 0);

      // R2 readback of maxima and control bits
      bus_wr(5'h08, 32'h1234_5678); bus_rd(5'h08, v); chk("R2 ref max", v, 32'h1234_5678);
      bus_wr(5'h10, 32'h9ABC_DEF0); bus_rd(5'h10, v); chk("R2 tst max", v, 32'h9ABC_DEF0);
      bus_wr(5'h00, 32'h33); bus_rd(5'h00, v); chk("R2 ctrl", v, 32'h33);
      bus_wr(5'h00, 32'h11);

      // R3 undefined offsets
      bus_wr(5'h18, 32'hFFFF_FFFF);
      bus_rd(5'h18, v); chk("R3 off 0x18", v, 0);
      bus_rd(5'h1C, v); chk("R3 off 0x1C", v, 0);

      // R7 flag bits not writable
      bus_wr(5'h00, 32'h55); bus_rd(5'h00, v); chk("R7 flag write ignored", v, 32'h11);

      // R4/R6/R7/R9 reference window sweep with free test limit
      for (int rl = 1; rl <= 24; rl++) begin
         measure(rl, 32'hFFFF_FFFF);
         nom = (rl * TREF) / TTST;
         bus_rd(5'h0C, v); chk("R4 ref count", v, rl);
         bus_rd(5'h14, v); chk_rng("R6 frozen test count", v, nom, nom + 26);
         bus_rd(5'h00, v); chk("R7 ctrl flags", v, 32'h26);
         bus_rd(5'h04, v); chk("R9 status", v, 32'h1);
         chk("R7 irq", {30'd0, irq_tst, irq_ref}, 32'h1);
      end

      // R5 test limit reached well before the window closes
      for (int tl = 1; tl <= 16; tl++) begin
         measure(40, tl);
         bus_rd(5'h14, v); chk("R5 test count", v, tl);
         bus_rd(5'h0C, v); chk("R4 ref count", v, 40);
         bus_rd(5'h00, v); chk("R7 ctrl both flags", v, 32'h66);
         bus_rd(5'h04, v); chk("R9 status both", v, 32'h3);
      end

      // R7 writing run bits without flag bits leaves flags set
      bus_wr(5'h00, 32'h22); bus_rd(5'h00, v); chk("R7 flags survive write", v, 32'h66);

      // R5 freeze and own limit near each other
      for (int tl = 28; tl <= 64; tl += 3) begin
         measure(8, tl);
         bus_rd(5'h14, v);
         chk_rng("R5 count within own limit", v, 1, tl);
         begin
            logic [31:0] st;
            bus_rd(5'h04, st);
            chk("R5 test flag iff at limit", {31'd0, st[1]}, {31'd0, (v == tl)});
         end
      end

      // R8 clear empties counts and flags
      bus_wr(5'h00, 32'h11);
      idle(80);
      bus_rd(5'h00, v); chk("R8 ctrl cleared", v, 32'h11);
      bus_rd(5'h0C, v); chk("R8 ref cnt cleared", v, 0);
      bus_rd(5'h14, v); chk("R8 tst cnt cleared", v, 0);
      bus_rd(5'h04, v); chk("R9 status cleared", v, 0);
      chk("R8 irq cleared", {30'd0, irq_tst, irq_ref}, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule